// File: doc/BRIEF.md
# Late-Data Detecting Pipeline Register Bank

This block is a pipeline register that notices when its data arrived too late. Every bit has a main flop that loads on the rising clock edge. Every bit also has a shadow copy that loads the same input a little later, on the rising edge of a separate delayed strobe. The shadow copy is treated as the trustworthy value. After the strobe, the block compares the main and shadow values in groups of bits called banks. A difference means the main flop caught stale data. That difference, or a metastability indication for the bank, is registered as a per-bank error on the next clock edge.

A controller responds by raising `restore`. On the next clock edge the main register then loads the shadow value instead of the incoming data, so the late value is recovered without losing a cycle of state. A sticky flag records that an error happened at some point and stays set until software-independent control logic clears it with `clear_sticky`.

The strobe must pulse at most once per clock cycle, between two rising clock edges. The comparison is meaningful only after such a pulse. In a cycle without a strobe pulse, no error is raised.

Top module: `timing_guard_bank`

## Requirements
- R1: While `rst_n` is low, `q`, `bank_err`, `sticky_err` and the shadow copy are all zero; a restore issued right after reset, before any strobe, loads zero.
- R2: On each rising `clk` edge with `restore` low, `q` takes the value of `d_in` present at that edge.
- R3: On the rising edge of `late_strobe` the shadow copy loads `d_in`. If the shadow differs from `q` anywhere in bank b after that pulse, `bank_err[b]` is 1 after the following rising `clk` edge. Bank b covers bits `[b*BANK_W +: BANK_W]`.
- R4: On a rising `clk` edge with `restore` high, `q` loads the shadow copy and `d_in` is ignored.
- R5: A high `meta_flag[b]` at a rising `clk` edge, after a strobe pulse in that cycle, sets `bank_err[b]` after that edge.
- R6: If no strobe pulse occurred since the previous rising `clk` edge, `bank_err` is all zero after the edge, whatever the mismatch or `meta_flag`.
- R7: `sticky_err` is set at the same edge at which any bit of `bank_err` becomes 1.
- R8: Once set, `sticky_err` stays 1 for as long as `clear_sticky` is low.
- R9: `clear_sticky` high at a rising edge clears `sticky_err`, unless a new bank error is registered at that same edge, in which case `sticky_err` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; the main register loads on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| late_strobe | input | 1 | Delayed sample strobe; the shadow copy loads on its rising edge |
| d_in | input | NUM_BANKS*BANK_W | Data arriving from the upstream logic |
| meta_flag | input | NUM_BANKS | Metastability indication per bank |
| restore | input | 1 | Replace the next main capture with the shadow value |
| clear_sticky | input | 1 | Clear the sticky error flag |
| q | output | NUM_BANKS*BANK_W | Main register output |
| bank_err | output | NUM_BANKS | Registered late-data error, one bit per bank |
| sticky_err | output | 1 | Accumulated error flag |

## Verification
The bench builds the block with two banks of four bits each. With that split, a late change confined to the low nibble, a late change confined to the high nibble, and a change spanning both banks each produce a different `bank_err` pattern, and the bench checks all three. Metastability is also injected into one bank while the other is clean. The narrow width lets every pattern be chosen by hand. Because of that, a restore can be driven while `d_in` carries a third, unrelated value, which shows that the shadow wins over the incoming data.

// File: rtl/tg_pkg.sv
package tg_pkg;

  // Source of the next main-register value
  typedef enum logic {
    SRC_INPUT  = 1'b0,
    SRC_SHADOW = 1'b1
  } cap_src_e;

  // Restore overrides incoming data
  function automatic cap_src_e pick_source(input logic restore);
    return restore ? SRC_SHADOW : SRC_INPUT;
  endfunction

  // A strobe pulse happened since the last clock edge when the toggles differ
  function automatic logic window_open(input logic stb_tog, input logic seen_tog);
    return stb_tog ^ seen_tog;
  endfunction

  // A new hit wins over a clear request
  function automatic logic sticky_next(input logic cur, input logic clr, input logic hit);
    return hit | (cur & ~clr);
  endfunction

endpackage

// File: rtl/tg_shadow_cap.sv
module tg_shadow_cap #(
  parameter int W = 8
) (
  input  logic         late_strobe,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] shadow,
  output logic         stb_tog
);

  // Late copy of the data plus a toggle marking each strobe pulse
  always_ff @(posedge late_strobe or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      stb_tog <= 1'b0;
    end else begin
      shadow  <= d_in;
      stb_tog <= ~stb_tog;
    end
  end

endmodule

// File: rtl/tg_window.sv
module tg_window (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_tog,
  output logic win_open
);

  logic seen_tog;

  // Clock-side record of the last strobe toggle seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_tog <= 1'b0;
    else        seen_tog <= stb_tog;
  end

  assign win_open = tg_pkg::window_open(stb_tog, seen_tog);

endmodule

// File: rtl/tg_main_reg.sv
module tg_main_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restore,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] shadow,
  output logic [W-1:0] q
);

  tg_pkg::cap_src_e src;
  logic [W-1:0]     next_q;

  assign src = tg_pkg::pick_source(restore);

  always_comb begin
    unique case (src)
      tg_pkg::SRC_SHADOW: next_q = shadow;
      default:            next_q = d_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_q;
  end

endmodule

// File: rtl/tg_err_merge.sv
module tg_err_merge #(
  parameter int NB = 2,
  parameter int BW = 4,
  localparam int W = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  q,
  input  logic [W-1:0]  shadow,
  input  logic          win_open,
  input  logic [NB-1:0] meta_flag,
  input  logic          clear_sticky,
  output logic [NB-1:0] err_next,
  output logic [NB-1:0] bank_err,
  output logic          sticky_err
);

  logic [NB-1:0] hit;

  // One comparator per bank
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign hit[b] = (|(q[b*BW +: BW] ^ shadow[b*BW +: BW])) | meta_flag[b];
  end

  assign err_next = win_open ? hit : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_err   <= '0;
      sticky_err <= 1'b0;
    end else begin
      bank_err   <= err_next;
      sticky_err <= tg_pkg::sticky_next(sticky_err, clear_sticky, |err_next);
    end
  end

endmodule

// File: rtl/timing_guard_bank.sv
module timing_guard_bank #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 4,
  localparam int W = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 late_strobe,
  input  logic [W-1:0]         d_in,
  input  logic [NUM_BANKS-1:0] meta_flag,
  input  logic                 restore,
  input  logic                 clear_sticky,
  output logic [W-1:0]         q,
  output logic [NUM_BANKS-1:0] bank_err,
  output logic                 sticky_err
);

  // Named internal events, visible to the bound checker
  logic [W-1:0]         shadow_q;
  logic                 stb_tog;
  logic                 win_open;
  logic [NUM_BANKS-1:0] err_next;

  tg_shadow_cap #(.W(W)) u_shadow (
    .late_strobe (late_strobe),
    .rst_n       (rst_n),
    .d_in        (d_in),
    .shadow      (shadow_q),
    .stb_tog     (stb_tog)
  );

  tg_window u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_tog  (stb_tog),
    .win_open (win_open)
  );

  tg_main_reg #(.W(W)) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .restore (restore),
    .d_in    (d_in),
    .shadow  (shadow_q),
    .q       (q)
  );

  tg_err_merge #(.NB(NUM_BANKS), .BW(BANK_W)) u_err (
    .clk          (clk),
    .rst_n        (rst_n),
    .q            (q),
    .shadow       (shadow_q),
    .win_open     (win_open),
    .meta_flag    (meta_flag),
    .clear_sticky (clear_sticky),
    .err_next     (err_next),
    .bank_err     (bank_err),
    .sticky_err   (sticky_err)
  );

endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int W  = 8,
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restore,
  input logic          clear_sticky,
  input logic [W-1:0]  d_in,
  input logic [NB-1:0] meta_flag,
  input logic [W-1:0]  q,
  input logic [W-1:0]  shadow,
  input logic          win_open,
  input logic [NB-1:0] err_next,
  input logic [NB-1:0] bank_err,
  input logic          sticky_err
);

  a_r2_capture_input: assert property (@(posedge clk) disable iff (!rst_n)
    !restore |=> q == $past(d_in));

  a_r4_restore_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> q == $past(shadow));

  a_r3_mismatch_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && (q != shadow)) |=> (|bank_err));

  a_r5_meta_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && (|meta_flag)) |=> (|bank_err));

  a_r6_closed_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> bank_err == '0);

  a_r7_sticky_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_err) |-> sticky_err);

  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_err && !clear_sticky) |=> sticky_err);

  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_sticky && (err_next == '0)) |=> !sticky_err);

endmodule

bind timing_guard_bank tg_checker #(.W(W), .NB(NUM_BANKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .restore      (restore),
  .clear_sticky (clear_sticky),
  .d_in         (d_in),
  .meta_flag    (meta_flag),
  .q            (q),
  .shadow       (shadow_q),
  .win_open     (win_open),
  .err_next     (err_next),
  .bank_err     (bank_err),
  .sticky_err   (sticky_err)
);

// File: tb/timing_guard_bank_test.sv
module timing_guard_bank_test;
  localparam int NB = 2;
  localparam int BW = 4;
  localparam int W  = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          late_strobe = 1'b0;
  logic          restore = 1'b0;
  logic          clear_sticky = 1'b0;
  logic [W-1:0]  d_in = '0;
  logic [NB-1:0] meta_flag = '0;
  wire  [W-1:0]  q;
  wire  [NB-1:0] bank_err;
  wire           sticky_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side model state
  logic [W-1:0] m_shadow = '0;
  logic         m_sticky = 1'b0;

  always #5 clk = ~clk;

  timing_guard_bank #(.NUM_BANKS(NB), .BANK_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .late_strobe(late_strobe), .d_in(d_in),
    .meta_flag(meta_flag), .restore(restore), .clear_sticky(clear_sticky),
    .q(q), .bank_err(bank_err), .sticky_err(sticky_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_err(input logic [W-1:0] main_v, input logic [W-1:0] late_v,
                                           input logic [NB-1:0] meta, input bit stb);
    logic [NB-1:0] r;
    for (int k = 0; k < NB; k++)
      r[k] = stb && ((main_v[k*BW +: BW] != late_v[k*BW +: BW]) || meta[k]);
    return r;
  endfunction

  // One scenario cycle: main loads data, d_in moves to late, optional strobe,
  // then controls for the following edge; checks after that edge.
  task automatic beat(input string tag, input logic [W-1:0] data, input logic [W-1:0] late,
                      input logic [W-1:0] tail, input bit stb, input logic [NB-1:0] meta,
                      input bit rest, input bit clr);
    logic [NB-1:0] e;
    logic [W-1:0]  eq;
    d_in = data;
    @(posedge clk);
    #1 d_in = late;
    #1 late_strobe = stb;
    #1 late_strobe = 1'b0;
    d_in = tail;
    meta_flag = meta;
    restore = rest;
    clear_sticky = clr;
    e = exp_err(data, late, meta, stb);
    if (stb) m_shadow = late;
    eq = rest ? m_shadow : tail;
    m_sticky = (m_sticky & ~clr) | (|e);
    @(posedge clk);
    #1 meta_flag = '0;
    restore = 1'b0;
    clear_sticky = 1'b0;
    chk({tag, " q"}, 32'(q), 32'(eq));
    chk({tag, " bank_err"}, 32'(bank_err), 32'(e));
    chk({tag, " sticky"}, 32'(sticky_err), 32'(m_sticky));
  endtask

  task automatic t_reset_state();
    chk("R1 q after reset", 32'(q), 0);
    chk("R1 bank_err after reset", 32'(bank_err), 0);
    chk("R1 sticky after reset", 32'(sticky_err), 0);
  endtask

  task automatic t_on_time();
    beat("R2 on-time data", 8'h3C, 8'h3C, 8'h3C, 1, 2'b00, 0, 0);
  endtask

  task automatic t_late_low_bank();
    beat("R3 R7 late low bank", 8'h30, 8'h35, 8'h35, 1, 2'b00, 0, 0);
  endtask

  task automatic t_sticky_hold();
    beat("R8 sticky holds", 8'h77, 8'h77, 8'h77, 1, 2'b00, 0, 0);
  endtask

  task automatic t_restore_high_bank();
    beat("R4 restore late high bank", 8'h12, 8'h92, 8'hE0, 1, 2'b00, 1, 0);
  endtask

  task automatic t_restore_no_strobe();
    beat("R4 R6 restore keeps old shadow", 8'h44, 8'h55, 8'h66, 0, 2'b00, 1, 0);
  endtask

  task automatic t_closed_window();
    beat("R6 no strobe ignores mismatch and meta", 8'h0F, 8'hF0, 8'hF0, 0, 2'b11, 0, 0);
  endtask

  task automatic t_meta();
    beat("R5 meta in high bank", 8'hA5, 8'hA5, 8'hA5, 1, 2'b10, 0, 0);
  endtask

  task automatic t_clear();
    beat("R9 clear sticky", 8'h5A, 8'h5A, 8'h5A, 1, 2'b00, 0, 1);
  endtask

  task automatic t_clear_vs_error();
    beat("R9 R7 error wins over clear", 8'h01, 8'h81, 8'h81, 1, 2'b00, 0, 1);
  endtask

  task automatic t_both_banks();
    beat("R3 R4 both banks late", 8'h00, 8'hFF, 8'h11, 1, 2'b00, 1, 0);
  endtask

  task automatic t_reset_midway();
    #3 rst_n = 1'b0;
    #2;
    chk("R1 q in reset", 32'(q), 0);
    chk("R1 bank_err in reset", 32'(bank_err), 0);
    chk("R1 sticky in reset", 32'(sticky_err), 0);
    m_shadow = '0;
    m_sticky = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    beat("R1 shadow cleared by reset", 8'h20, 8'h20, 8'h99, 0, 2'b00, 1, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #4 t_reset_state();
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_on_time();
    t_late_low_bank();
    t_sticky_hold();
    t_restore_high_bank();
    t_restore_no_strobe();
    t_closed_window();
    t_meta();
    t_clear();
    t_clear_vs_error();
    t_both_banks();
    t_reset_midway();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule